// File: doc/BRIEF.md
# Receive Descriptor Buffer Manager

This block sits behind the receive MAC and places each accepted Ethernet frame into system memory through a ring of two-word receive descriptors. When a frame starts with its address-recognized flag high, the block reads the first word of the current descriptor. If software still owns that descriptor, the block throws the whole frame away and bumps a resource-error statistic. Otherwise it copies the frame byte by byte into the buffer named by that word. It then writes the frame length into the second word, and last marks the first word as used. The ring position advances by one descriptor, or returns to the ring base when the descriptor carries the wrap flag.

The frame stream has no back-pressure. The block holds one byte for memory. If the memory port has not granted that byte's write before the next byte arrives, or if the port answers with an error, the frame is abandoned as a receive overrun. The descriptor is left untouched so that the next recognized frame lands in the same buffer. An optional mode keeps the four trailing frame check bytes out of memory and reports a length shortened by four.

Top module: `rxdm_top`

## Requirements
- R1: A frame whose start byte arrives with `rx_addr_hit` low makes no memory request at all, and the descriptor ring position stays where it was.
- R2: A start byte with `rx_addr_hit` high causes a read of the descriptor word at `cfg_ring_base` plus the ring offset. If bit 0 of that word is 1, the rest of the frame is discarded, and neither buffer bytes nor descriptor words are written.
- R3: Every frame discarded under R2 increments `stat_rsrc_err` by exactly one.
- R4: The n-th stored byte (counting from 0) goes to byte address `{word0[31:2],2'b00} + n`. The write puts the byte in all four lanes of `mem_wdata` and enables only lane `address[1:0]` in `mem_be`.
- R5: When a frame completes, the second descriptor word (first word address + 4) is written with the length in bits 11:0 and zeros above. The first word is then written back with bit 0 set, and `irq_rx_done` pulses for one cycle.
- R6: After a completed frame, the next descriptor is at the ring base if bit 1 of the used first word was 1. Otherwise it is 8 bytes further on.
- R7: With `cfg_strip_fcs` high at the start byte, the last four bytes of the frame are not written, and the reported length is the byte count minus four (zero for frames of four bytes or fewer).
- R8: A write answered with `mem_err` raises a one-cycle `irq_overrun` pulse. The rest of the frame is ignored and no descriptor word is written. The next recognized frame reuses the same descriptor and buffer.
- R9: If a byte arrives while the previous byte's write is still waiting for `mem_gnt`, the result is an overrun with the same effects as R8.
- R10: A request that is not granted stays asserted with the same address on the next cycle, unless that cycle reports an overrun.
- R11: After reset there is no memory request, both interrupts are low, `stat_rsrc_err` is zero, and the first descriptor read is at `cfg_ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_addr_hit | input | 1 | Destination address was recognized (sampled with the first byte) |
| rx_byte | input | 8 | Frame byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_gnt | input | 1 | Request accepted this cycle; read data valid |
| mem_err | input | 1 | Accepted access failed (valid with mem_gnt) |
| mem_rdata | input | 32 | Read data |
| cfg_ring_base | input | AW | Byte address of the first descriptor |
| cfg_strip_fcs | input | 1 | Keep the four trailing check bytes out of memory |
| irq_rx_done | output | 1 | One-cycle pulse per stored frame |
| irq_overrun | output | 1 | One-cycle pulse per receive overrun |
| stat_rsrc_err | output | CNT_W | Count of frames lost to software-owned descriptors |

## Verification
The main path is exercised with a sequence of frames that differ in length, address-recognized flag, descriptor ownership and stripping mode. Comparing buffer bytes, descriptor words, the statistic and the interrupt counts after each frame separates the store, discard and drop outcomes. The sequence crosses a wrap descriptor, so the descriptor address sequence shows the wrap return. Two overrun frames follow, one caused by an error response and one by a withheld grant, and each is followed by a clean frame whose placement shows that the same descriptor was reused. Frames shorter than the stripped tail cover the zero-length corner.

// File: rtl/rxdm_pkg.sv
package rxdm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DESC = 3'd1,
        ST_DATA = 3'd2,
        ST_LEN  = 3'd3,
        ST_OWN  = 3'd4,
        ST_DROP = 3'd5
    } rxdm_state_e;

    localparam int SW_OWN_BIT  = 0;
    localparam int RING_WRAP_BIT = 1;
    localparam int DESC_STRIDE = 8;
    localparam int LEN_WORD_OFS = 4;
    localparam int FCS_BYTES   = 4;

endpackage

// File: rtl/rxdm_tail_hold.sv
module rxdm_tail_hold #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         bypass,
    input  logic         in_v,
    input  logic [W-1:0] in_byte,
    output logic         out_v,
    output logic [W-1:0] out_byte
);
    localparam int FW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] sr;
        logic [FW-1:0]           fill;
    } hold_t;

    hold_t h_d, h_q;
    logic [FW-1:0] fill_eff;

    always_comb begin
        h_d      = h_q;
        fill_eff = clear ? '0 : h_q.fill;
        out_v    = 1'b0;
        out_byte = h_q.sr[DEPTH-1];
        if (bypass) begin
            out_v    = in_v;
            out_byte = in_byte;
            h_d.fill = fill_eff;
        end else if (in_v) begin
            out_v = (fill_eff == FW'(DEPTH));
            for (int i = DEPTH - 1; i > 0; i--) begin
                h_d.sr[i] = h_q.sr[i-1];
            end
            h_d.sr[0] = in_byte;
            h_d.fill  = (fill_eff == FW'(DEPTH)) ? fill_eff : fill_eff + FW'(1);
        end else begin
            h_d.fill = fill_eff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

endmodule

// File: rtl/rxdm_evt_counter.sv
module rxdm_evt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] c_d, c_q;

    always_comb begin
        c_d = c_q + W'(inc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count = c_q;

    // R3: the statistic moves by one step at a time
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + W'(1)));

endmodule

// File: rtl/rxdm_top.sv
module rxdm_top
    import rxdm_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 12,
    parameter int OFF_W = 10,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_addr_hit,
    input  logic [7:0]       rx_byte,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    output logic [3:0]       mem_be,
    input  logic             mem_gnt,
    input  logic             mem_err,
    input  logic [31:0]      mem_rdata,
    input  logic [AW-1:0]    cfg_ring_base,
    input  logic             cfg_strip_fcs,
    output logic             irq_rx_done,
    output logic             irq_overrun,
    output logic [CNT_W-1:0] stat_rsrc_err
);
    typedef struct packed {
        rxdm_state_e      st;
        logic [OFF_W-1:0] off;
        logic [31:0]      w0;
        logic [LEN_W-1:0] cnt;
        logic             pend_v;
        logic [7:0]       pend;
        logic             eof_seen;
        logic             strip;
        logic             irq_done;
        logic             irq_ovr;
    } regs_t;

    regs_t r_d, r_q;

    logic          take, strip_now, tail_v;
    logic [7:0]    tail_b;
    logic          wr_done, ovr, rsrc_inc, eof_now;
    logic [AW-1:0] desc_addr, data_addr;

    assign strip_now = (r_q.st == ST_IDLE) ? cfg_strip_fcs : r_q.strip;
    assign take = rx_valid &&
                  (((r_q.st == ST_IDLE) && rx_sof && rx_addr_hit) ||
                   (((r_q.st == ST_DESC) || (r_q.st == ST_DATA)) && !r_q.eof_seen));

    rxdm_tail_hold #(.DEPTH(FCS_BYTES), .W(8)) u_tail (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (r_q.st == ST_IDLE),
        .bypass   (!strip_now),
        .in_v     (take),
        .in_byte  (rx_byte),
        .out_v    (tail_v),
        .out_byte (tail_b)
    );

    rxdm_evt_counter #(.W(CNT_W)) u_rsrc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rsrc_inc),
        .count (stat_rsrc_err)
    );

    always_comb begin
        r_d          = r_q;
        r_d.irq_done = 1'b0;
        r_d.irq_ovr  = 1'b0;
        desc_addr    = cfg_ring_base + AW'(r_q.off);
        data_addr    = AW'({r_q.w0[31:2], 2'b00}) + AW'(r_q.cnt);
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = desc_addr;
        mem_wdata    = '0;
        mem_be       = 4'hF;
        rsrc_inc     = 1'b0;
        wr_done      = 1'b0;
        ovr          = 1'b0;
        eof_now      = r_q.eof_seen || (take && rx_eof);

        case (r_q.st)
            ST_IDLE: begin
                if (rx_valid && rx_sof) begin
                    if (rx_addr_hit) begin
                        r_d.st       = ST_DESC;
                        r_d.cnt      = '0;
                        r_d.eof_seen = 1'b0;
                        r_d.strip    = cfg_strip_fcs;
                        r_d.pend_v   = 1'b0;
                    end else if (!rx_eof) begin
                        r_d.st = ST_DROP;
                    end
                end
            end
            ST_DESC: begin
                mem_req = 1'b1;
                if (mem_gnt) begin
                    if (mem_err) begin
                        ovr = 1'b1;
                    end else if (mem_rdata[SW_OWN_BIT]) begin
                        rsrc_inc   = 1'b1;
                        r_d.pend_v = 1'b0;
                        r_d.st     = eof_now ? ST_IDLE : ST_DROP;
                    end else begin
                        r_d.w0 = mem_rdata;
                        r_d.st = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (r_q.pend_v) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = data_addr;
                    mem_wdata = {4{r_q.pend}};
                    mem_be    = 4'b0001 << data_addr[1:0];
                    if (mem_gnt) begin
                        if (mem_err) begin
                            ovr = 1'b1;
                        end else begin
                            wr_done = 1'b1;
                            r_d.cnt = r_q.cnt + LEN_W'(1);
                        end
                    end
                end else if (r_q.eof_seen) begin
                    r_d.st = ST_LEN;
                end
            end
            ST_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + AW'(LEN_WORD_OFS);
                mem_wdata = 32'(r_q.cnt);
                if (mem_gnt) begin
                    if (mem_err) ovr = 1'b1;
                    else         r_d.st = ST_OWN;
                end
            end
            ST_OWN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = r_q.w0 | 32'(1 << SW_OWN_BIT);
                if (mem_gnt) begin
                    if (mem_err) begin
                        ovr = 1'b1;
                    end else begin
                        r_d.irq_done = 1'b1;
                        r_d.off      = r_q.w0[RING_WRAP_BIT] ? '0
                                       : r_q.off + OFF_W'(DESC_STRIDE);
                        r_d.st       = ST_IDLE;
                    end
                end
            end
            ST_DROP: begin
                if (rx_valid && rx_eof) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (wr_done) r_d.pend_v = 1'b0;
        if (tail_v && (r_d.st != ST_DROP) && !(r_q.st == ST_DESC && rsrc_inc)) begin
            if (r_d.pend_v) begin
                ovr = 1'b1;
            end else begin
                r_d.pend_v = 1'b1;
                r_d.pend   = tail_b;
            end
        end
        if (take && rx_eof) r_d.eof_seen = 1'b1;
        if (ovr) begin
            r_d.irq_ovr = 1'b1;
            r_d.pend_v  = 1'b0;
            r_d.st      = eof_now ? ST_IDLE : ST_DROP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq_rx_done = r_q.irq_done;
    assign irq_overrun = r_q.irq_ovr;

    // R10: an ungranted request is held with its address unless an overrun follows
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> ((mem_req && $stable(mem_addr)) || irq_overrun));

    // R5: completion only follows an accepted write that sets the ownership bit
    assert_done_after_own_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_done |-> $past(mem_req && mem_we && mem_gnt && !mem_err && mem_wdata[SW_OWN_BIT]));

    // R8: a frame is never both completed and overrun
    assert_irq_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_rx_done && irq_overrun));

    // R8: an overrun pulse follows an error response or a starved request
    assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_overrun |-> $past(mem_req && (mem_err || !mem_gnt)));

endmodule

// File: tb/tb_rxdm_top.sv
`timescale 1ns/1ps
module tb_rxdm_top;

    localparam logic [31:0] BASE = 32'h10;
    localparam logic [31:0] MARK = 32'h5A5A0000;
    // fields: len[11:4], hit[3], own[2], strip[1], spare[0]
    localparam logic [11:0] VEC [0:5] = '{
        {8'd8,  1'b1, 1'b0, 1'b0, 1'b0},
        {8'd10, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'd6,  1'b0, 1'b0, 1'b0, 1'b0},
        {8'd7,  1'b1, 1'b1, 1'b0, 1'b0},
        {8'd5,  1'b1, 1'b0, 1'b0, 1'b0},
        {8'd3,  1'b1, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        rx_valid, rx_sof, rx_eof, rx_addr_hit;
    logic [7:0]  rx_byte;
    logic        mem_req, mem_we, mem_gnt, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        cfg_strip_fcs;
    logic        irq_rx_done, irq_overrun;
    logic [15:0] stat_rsrc_err;

    logic [31:0] mem [0:63];
    logic        blk_wr = 1'b0;
    logic        err_wr = 1'b0;
    logic [31:0] last_rd = 32'hFFFF_FFFF;
    int n_chk = 0, n_fail = 0, n_done = 0, n_ovr = 0;

    rxdm_top dut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_addr_hit(rx_addr_hit), .rx_byte(rx_byte),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .cfg_ring_base(BASE), .cfg_strip_fcs(cfg_strip_fcs),
        .irq_rx_done(irq_rx_done), .irq_overrun(irq_overrun),
        .stat_rsrc_err(stat_rsrc_err)
    );

    assign mem_gnt   = mem_req && !(blk_wr && mem_we);
    assign mem_err   = mem_gnt && err_wr && mem_we;
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (mem_req && mem_gnt && !mem_err) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                last_rd <= mem_addr;
            end
        end
        if (rst_n) begin
            n_done <= n_done + int'(irq_rx_done);
            n_ovr  <= n_ovr + int'(irq_overrun);
        end
    end

    function automatic logic [7:0] get_byte(input logic [31:0] a);
        return mem[a[7:2]][8*a[1:0] +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    task automatic init_descs(input bit own0, input bit own1);
        for (int i = 16; i < 48; i++) mem[i] = 32'hEEEE_EEEE;
        mem[4] = 32'h40 | 32'(own0);
        mem[5] = MARK;
        mem[6] = 32'h82 | 32'(own1);
        mem[7] = MARK;
    endtask

    task automatic send_frame(input int len, input bit hit, input logic [7:0] seed,
                              input bit probe, input logic [31:0] probe_addr);
        for (int i = 0; i < len; i++) begin
            if (probe && i == 1) begin
                chk(mem_req && mem_we && mem_addr == probe_addr, "R10 held request",
                    mem_addr, probe_addr);
            end
            @(negedge clk);
            rx_valid    = 1'b1;
            rx_sof      = (i == 0);
            rx_eof      = (i == len - 1);
            rx_byte     = seed + 8'(i);
            rx_addr_hit = hit;
            @(negedge clk);
            rx_valid = 1'b0;
            rx_sof   = 1'b0;
            rx_eof   = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R11 actual=timeout expected=finish");
        report();
    end

    initial begin
        int exp_idx, rsrc_exp, done_exp, ovr_exp;
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_addr_hit = 0; rx_byte = 0;
        cfg_strip_fcs = 0;
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        init_descs(1'b0, 1'b0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(!mem_req, "R11 no request", 32'(mem_req), 0);
        chk(!irq_rx_done, "R11 done low", 32'(irq_rx_done), 0);
        chk(!irq_overrun, "R11 overrun low", 32'(irq_overrun), 0);
        chk(stat_rsrc_err == 0, "R11 statistic zero", 32'(stat_rsrc_err), 0);

        exp_idx = 0; rsrc_exp = 0; done_exp = 0; ovr_exp = 0;
        for (int k = 0; k < 6; k++) begin
            logic [11:0] v;
            int len, d0, explen;
            bit hit, own, strip, accept;
            logic [31:0] bufa, rd_before, dadr;
            logic [7:0] seed;
            bit bytes_ok;
            v = VEC[k];
            len = int'(v[11:4]); hit = v[3]; own = v[2]; strip = v[1];
            accept = hit && !own;
            d0 = (exp_idx == 1) ? 6 : 4;
            dadr = BASE + 32'(exp_idx * 8);
            bufa = (exp_idx == 1) ? 32'h80 : 32'h40;
            seed = 8'(k * 16 + 1);
            init_descs(own && exp_idx == 0, own && exp_idx == 1);
            cfg_strip_fcs = strip;
            rd_before = last_rd;
            send_frame(len, hit, seed, 1'b0, 32'h0);
            if (hit && own) rsrc_exp++;
            if (accept) done_exp++;
            explen = !accept ? 0 : (strip ? ((len > 4) ? len - 4 : 0) : len);
            chk(stat_rsrc_err == 16'(rsrc_exp), "R3 resource count", 32'(stat_rsrc_err), 32'(rsrc_exp));
            chk(n_done == done_exp, "R5 done pulses", 32'(n_done), 32'(done_exp));
            if (k == 0) chk(last_rd == BASE, "R11 first descriptor at base", last_rd, BASE);
            if (accept) begin
                chk(mem[d0+1] == 32'(explen), "R5 R7 length word", mem[d0+1], 32'(explen));
                chk(mem[d0][0] == 1'b1, "R5 ownership set", mem[d0], mem[d0] | 32'h1);
                chk(last_rd == dadr, "R2 R6 descriptor address", last_rd, dadr);
                bytes_ok = 1'b1;
                for (int i = 0; i < explen; i++)
                    if (get_byte(bufa + 32'(i)) != seed + 8'(i)) bytes_ok = 1'b0;
                chk(bytes_ok, "R4 buffer bytes", 32'(get_byte(bufa)), 32'(seed));
                chk(get_byte(bufa + 32'(explen)) == 8'hEE, "R7 tail not stored",
                    32'(get_byte(bufa + 32'(explen))), 32'hEE);
                if (dadr == BASE + 32'h8) exp_idx = 0;
                else exp_idx = 1;
            end else begin
                chk(mem[d0+1] == MARK, "R1 R2 length word untouched", mem[d0+1], MARK);
                chk(get_byte(bufa) == 8'hEE, "R1 R2 buffer untouched", 32'(get_byte(bufa)), 32'hEE);
                if (!hit) chk(last_rd == rd_before, "R1 no descriptor read", last_rd, rd_before);
                else chk(last_rd == dadr, "R2 R6 descriptor address after wrap", last_rd, dadr);
            end
        end

        // R8 error response, then reuse
        init_descs(1'b0, 1'b0);
        cfg_strip_fcs = 1'b0;
        err_wr = 1'b1;
        send_frame(6, 1'b1, 8'hA0, 1'b0, 32'h0);
        err_wr = 1'b0;
        ovr_exp++;
        chk(n_ovr == ovr_exp, "R8 overrun pulse", 32'(n_ovr), 32'(ovr_exp));
        chk(n_done == done_exp, "R8 no completion", 32'(n_done), 32'(done_exp));
        chk(mem[5] == MARK, "R8 length word untouched", mem[5], MARK);
        send_frame(5, 1'b1, 8'hB0, 1'b0, 32'h0);
        done_exp++;
        chk(mem[5] == 32'd5, "R8 same descriptor reused", mem[5], 32'd5);
        chk(get_byte(32'h40) == 8'hB0, "R8 same buffer reused", 32'(get_byte(32'h40)), 32'hB0);
        chk(n_done == done_exp, "R8 recovery completes", 32'(n_done), 32'(done_exp));

        // R9 late grant, then reuse
        init_descs(1'b0, 1'b0);
        blk_wr = 1'b1;
        send_frame(6, 1'b1, 8'hC0, 1'b1, 32'h80);
        blk_wr = 1'b0;
        ovr_exp++;
        chk(n_ovr == ovr_exp, "R9 overrun pulse", 32'(n_ovr), 32'(ovr_exp));
        chk(mem[7] == MARK, "R9 length word untouched", mem[7], MARK);
        chk(get_byte(32'h80) == 8'hEE, "R9 buffer untouched", 32'(get_byte(32'h80)), 32'hEE);
        send_frame(4, 1'b1, 8'hD0, 1'b0, 32'h0);
        done_exp++;
        chk(mem[7] == 32'd4, "R9 same descriptor reused", mem[7], 32'd4);
        chk(get_byte(32'h80) == 8'hD0, "R9 same buffer reused", 32'(get_byte(32'h80)), 32'hD0);
        chk(n_done == done_exp, "R9 recovery completes", 32'(n_done), 32'(done_exp));

        report();
    end

endmodule